// File: doc/BRIEF.md
# Microtile-Swizzled Address Walker

This block turns a rectangular pixel box inside a tiled image into a stream of byte offsets, one per pixel. The image is made of 64-byte microtiles whose shape depends on the pixel size. A start strobe loads the box origin, width, height, pixel-size code and image row pitch in bytes. The block then emits one tiled byte offset per pixel over a valid/ready handshake. Pixels go row by row, and left to right within a row. After the last pixel it pulses done.

Each offset is split into an X field and a Y field, and the two fields occupy disjoint bits. Each field is advanced in place by subtracting its own bit mask and masking the result. This moves the field to the next logical coordinate without recomputing the swizzle for each pixel. When the Y field wraps past the bottom of a microtile, the X start of each row grows by one microtile-row increment. The block also reports whether the box lines up with microtile boundaries, so the caller can choose a faster copy path.

Top module: `lt_addr_walker`

## Requirements
- R1: `pix_sz` encodes the pixel size as 0=1, 1=2, 2=4 and 3=8 bytes. The microtile (width x height in pixels) is 8x8, 8x4, 4x4 and 2x4 for these codes.
- R2: For a pixel at column x, the X part of the offset is (x mod TW)*B + (x div TW)*64. Here B is bytes per pixel and TW is the microtile width.
- R3: For a pixel at row y, the offset adds (y mod TH)*TW*B and (y div TH)*P. Here TH is the microtile height and P is the X part of (pitch ÷ B). The pitch is assumed to be a multiple of TW*B.
- R4: Exactly width*height beats are emitted, in raster order. `out_valid` is low whenever `busy` is low.
- R5: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. `busy` falls in that same cycle.
- R6: If width or height is zero, the walk ends immediately. `done` pulses in the cycle after start, and no beat is produced.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_offset` holds its value.
- R8: A start strobe while `busy` is high is ignored. The walk in progress continues with its original parameters.
- R9: `aligned` is 1 when x and width are multiples of TW and y and height are multiples of TH. It is 0 otherwise. It holds its value for the whole walk.
- R10: The X and Y field masks never overlap. `mask_err` stays 0.
- R11: After reset, `busy`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a walk when idle |
| org_x | input | 16 | box left column |
| org_y | input | 16 | box top row |
| box_w | input | 16 | box width in pixels |
| box_h | input | 16 | box height in pixels |
| pix_sz | input | 2 | pixel size code |
| row_pitch | input | 32 | image row pitch in bytes |
| busy | output | 1 | walk in progress |
| aligned | output | 1 | box lies on microtile boundaries |
| mask_err | output | 1 | X and Y masks overlap |
| out_valid | output | 1 | offset beat available |
| out_ready | input | 1 | consumer accepts beat |
| out_offset | output | 32 | tiled byte offset of current pixel |
| done | output | 1 | one-cycle end-of-walk pulse |

## Verification
The bench drives boxes that start inside a microtile and cross one or more microtile rows, for every pixel size. A design that failed to add the row increment when the Y field wraps would repeat the offsets of the first microtile row. A mixed-up swizzle would place bytes in the wrong lanes, and the bench compares every beat against an arithmetic model to catch this. Irregular backpressure exposes offsets that drift while a beat is stalled. Zero-size boxes catch a walker that emits a stray beat or never finishes. A start strobe in the middle of a walk catches a design that reloads its parameters and corrupts the stream.

// File: rtl/lt_addr_walker.sv
module lt_addr_walker #(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [CW-1:0] box_w,
  input  logic [CW-1:0] box_h,
  input  logic [1:0]    pix_sz,
  input  logic [AW-1:0] row_pitch,
  output logic          busy,
  output logic          aligned,
  output logic          mask_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_offset,
  output logic          done
);

  function automatic logic [31:0] swz_x(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    swz_x = {v[28:3], 3'b000, v[2:0]};
      2'd1:    swz_x = {v[28:3], 2'b00, v[2:0], 1'b0};
      2'd2:    swz_x = {v[27:2], 2'b00, v[1:0], 2'b00};
      default: swz_x = {v[26:1], 2'b00, v[0], 3'b000};
    endcase
  endfunction

  function automatic logic [31:0] swz_y(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 2'd0) swz_y = {26'd0, v[2:0], 3'b000};
    else            swz_y = {26'd0, v[1:0], 4'b0000};
  endfunction

  logic [CW-1:0] w_r, h_r, col, row;
  logic [AW-1:0] xmask_r, ymask_r, incr_r, x0_r, xo_r, yo_r;

  wire go   = start && !busy;
  wire fire = busy && out_ready;

  wire [1:0] tw_lg = (pix_sz == 2'd3) ? 2'd1 : (pix_sz == 2'd2) ? 2'd2 : 2'd3;
  wire [1:0] th_lg = (pix_sz == 2'd0) ? 2'd3 : 2'd2;
  wire [CW-1:0] tw_m = CW'((1 << tw_lg) - 1);
  wire [CW-1:0] th_m = CW'((1 << th_lg) - 1);

  wire [AW-1:0] st_incr = swz_x(row_pitch >> pix_sz, pix_sz);
  wire [CW-1:0] st_trow = org_y >> th_lg;
  wire [AW-1:0] st_x0   = swz_x({{(32-CW){1'b0}}, org_x}, pix_sz)
                          + st_incr * {{(AW-CW){1'b0}}, st_trow};
  wire st_empty = (box_w == '0) || (box_h == '0);
  wire st_align = ((org_x & tw_m) == '0) && ((box_w & tw_m) == '0) &&
                  ((org_y & th_m) == '0) && ((box_h & th_m) == '0);

  wire last_col = (col == w_r - 1'b1);
  wire last_row = (row == h_r - 1'b1);
  wire [AW-1:0] y_next = (yo_r - ymask_r) & ymask_r;
  wire [AW-1:0] x_next = (xo_r - xmask_r) & xmask_r;

  assign out_valid  = busy;
  assign out_offset = yo_r + xo_r;
  assign mask_err   = |(xmask_r & ymask_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; aligned <= 1'b0;
      w_r <= '0; h_r <= '0; col <= '0; row <= '0;
      xmask_r <= '0; ymask_r <= '0; incr_r <= '0;
      x0_r <= '0; xo_r <= '0; yo_r <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        w_r     <= box_w;
        h_r     <= box_h;
        col     <= '0;
        row     <= '0;
        xmask_r <= swz_x('1, pix_sz);
        ymask_r <= swz_y('1, pix_sz);
        incr_r  <= st_incr;
        x0_r    <= st_x0;
        xo_r    <= st_x0;
        yo_r    <= swz_y({{(32-CW){1'b0}}, org_y}, pix_sz);
        aligned <= st_align;
        busy    <= !st_empty;
        done    <= st_empty;
      end else if (fire) begin
        if (last_col) begin
          col  <= '0;
          row  <= row + 1'b1;
          yo_r <= y_next;
          if (y_next == '0) begin
            x0_r <= x0_r + incr_r;
            xo_r <= x0_r + incr_r;
          end else begin
            xo_r <= x0_r;
          end
          if (last_row) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          col  <= col + 1'b1;
          xo_r <= x_next;
        end
      end
    end
  end

endmodule

module lt_addr_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          aligned,
  input logic          mask_err,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_offset,
  input logic          done
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offset));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_idle_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !out_ready |=> busy);

  assert_aligned_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(aligned));

  assert_masks_disjoint_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_err);

endmodule

bind lt_addr_walker lt_addr_walker_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .aligned(aligned),
  .mask_err(mask_err), .out_valid(out_valid), .out_ready(out_ready),
  .out_offset(out_offset), .done(done)
);

// File: tb/test_lt_addr_walker.sv
module test_lt_addr_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] org_x = '0, org_y = '0, box_w = '0, box_h = '0;
  logic [1:0] pix_sz = '0;
  logic [31:0] row_pitch = '0;
  logic out_ready = 1'b0;
  logic busy, aligned, mask_err, out_valid, done;
  logic [31:0] out_offset;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lt_addr_walker i_lt_addr_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .box_w(box_w), .box_h(box_h), .pix_sz(pix_sz), .row_pitch(row_pitch),
    .busy(busy), .aligned(aligned), .mask_err(mask_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_offset(out_offset), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bpp_of(input int sz); return 1 << sz; endfunction
  function automatic int tw_of(input int sz); return (sz == 3) ? 2 : (sz == 2) ? 4 : 8; endfunction
  function automatic int th_of(input int sz); return (sz == 0) ? 8 : 4; endfunction

  function automatic longint ref_x(input longint x, input int sz);
    return (x % tw_of(sz)) * bpp_of(sz) + (x / tw_of(sz)) * 64;
  endfunction

  function automatic longint ref_off(input int x, input int y, input int sz, input int pitch);
    longint p;
    p = ref_x(pitch / bpp_of(sz), sz);
    return ref_x(x, sz) + (y % th_of(sz)) * tw_of(sz) * bpp_of(sz) + (y / th_of(sz)) * p;
  endfunction

  task automatic walk(input int ox, input int oy, input int w, input int h, input int sz,
                      input int pitch, input bit bp, input bit poke);
    int n = 0;
    int cyc = 0;
    bit held = 0;
    bit fin = 0;
    bit prev_acc = 0;
    logic [31:0] hv = '0;
    bit exp_al;
    exp_al = (ox % tw_of(sz) == 0) && (w % tw_of(sz) == 0) &&
             (oy % th_of(sz) == 0) && (h % th_of(sz) == 0);
    @(negedge clk);
    org_x = 16'(ox); org_y = 16'(oy); box_w = 16'(w); box_h = 16'(h);
    pix_sz = 2'(sz); row_pitch = 32'(pitch); start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(aligned == exp_al, "R9 aligned flag", aligned, exp_al);
    chk(mask_err == 1'b0, "R10 mask overlap", mask_err, 0);
    while (!fin && cyc < 4000) begin
      if (done) begin
        chk(n == w * h, "R4 beat count", n, w * h);
        chk(!busy, "R5 busy low at done", busy, 0);
        chk(prev_acc || (w * h == 0), "R5 done timing", prev_acc, 1);
        if (w * h == 0) chk(cyc == 0, "R6 empty box done at once", cyc, 0);
        fin = 1;
      end else begin
        if (held) chk(out_valid && out_offset == hv, "R7 hold under stall", out_offset, hv);
        if (poke && cyc == 3) begin
          org_x = 16'd0; org_y = 16'd0; box_w = 16'd1; box_h = 16'd1;
          pix_sz = 2'd0; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        out_ready = bp ? (cyc % 3 != 1) : 1'b1;
        prev_acc = 0;
        held = 0;
        if (out_valid) begin
          if (out_ready) begin
            longint e;
            e = ref_off(ox + n % w, oy + n / w, sz, pitch);
            chk(out_offset == e, poke ? "R8 walk after ignored start" : "R1 R2 R3 offset", out_offset, e);
            n++;
            prev_acc = (n == w * h);
          end else begin
            held = 1;
            hv = out_offset;
          end
        end
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(fin, "R5 walk finished", fin, 1);
  endtask

  task automatic t_reset;
    chk(!busy && !out_valid && !done, "R11 reset state", {busy, out_valid, done}, 0);
  endtask

  task automatic t_sizes;
    walk(5, 6, 7, 11, 0, 64, 0, 0);
    walk(3, 2, 9, 7, 1, 96, 1, 0);
    walk(2, 3, 6, 6, 2, 64, 0, 0);
    walk(1, 1, 5, 9, 3, 64, 1, 0);
  endtask

  task automatic t_aligned;
    walk(4, 8, 8, 4, 2, 128, 0, 0);
    walk(0, 0, 16, 8, 0, 256, 1, 0);
  endtask

  task automatic t_empty;
    walk(3, 3, 0, 5, 1, 64, 0, 0);
    walk(3, 3, 4, 0, 2, 64, 0, 0);
  endtask

  task automatic t_busy_start;
    walk(2, 5, 6, 6, 2, 64, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_aligned();
    t_empty();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule